// File: doc/BRIEF.md
# Four-Function Arithmetic/Logic Unit with Condition Flags

This block is a purely combinational arithmetic/logic unit. It takes two operand words and a 2-bit function code. It returns a result word together with three condition flags: signed overflow, zero, and carry/borrow. The four functions are addition, subtraction, bitwise AND and bitwise XOR.

There is no clock and no internal state, so the outputs settle whenever any input changes. A surrounding datapath that needs to keep the flags for later decisions latches them in its own register. The word width is a parameter.

Top module: `arith_logic_unit`

## Requirements
- R1: With func_sel = 2'b00 the result is opnd_x + opnd_y, truncated to the word width.
- R2: With func_sel = 2'b01 the result is opnd_x - opnd_y, truncated to the word width.
- R3: With func_sel = 2'b10 the result is the bitwise AND of the two operands.
- R4: With func_sel = 2'b11 the result is the bitwise XOR of the two operands.
- R5: All outputs are combinational functions of the inputs and settle after any input change with no clock edge.
- R6: zero_flag is 1 exactly when every bit of result is 0, under every function code.
- R7: For addition, carry_flag is the carry out of the most significant bit.
- R8: For subtraction, carry_flag is the borrow out of the most significant bit, which is 1 exactly when opnd_x < opnd_y as unsigned numbers.
- R9: For addition and subtraction, ovf_flag is 1 exactly when the true two's-complement result does not fit in the word.
- R10: For AND and XOR, both ovf_flag and carry_flag are 0.
- R11: The word width is the parameter WIDTH, with a default of 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | WIDTH | First operand |
| opnd_y | input | WIDTH | Second operand (subtrahend for subtraction) |
| func_sel | input | 2 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| result | output | WIDTH | Result word |
| ovf_flag | output | 1 | Two's-complement overflow |
| zero_flag | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Carry out (add) or borrow out (subtract) |

## Verification
The block holds no state, so any internal fault shows up at the ports in the same evaluation as the input that triggers it. No later cycle is involved. A wrong carry-chain polarity appears in carry_flag only on the boundary operands: wrapping to zero, or subtracting a larger unsigned value. A wrong overflow term appears only when the operand signs meet a sign change in the result. The stimulus therefore aims at the word's sign and wrap boundaries under each function code. It also confirms that the flags of the logic functions stay clear even when operands sit at those same boundaries.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_AND = 2'd2,
    FN_XOR = 2'd3
  } alu_fn_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder for add and subtract; subtract inverts Y and injects a carry-in.
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic             sub_en,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] y_eff;
  logic [WIDTH:0]   wide_sum;

  always_comb begin
    y_eff     = opnd_y ^ {WIDTH{sub_en}};
    wide_sum  = {1'b0, opnd_x} + {1'b0, y_eff} + {{WIDTH{1'b0}}, sub_en};
    sum       = wide_sum[MSB:0];
    // Borrow is the inverted carry of the complemented addition.
    carry_out = wide_sum[WIDTH] ^ sub_en;
    ovf       = (opnd_x[MSB] == y_eff[MSB]) && (wide_sum[MSB] != opnd_x[MSB]);
  end

endmodule

// File: rtl/alu_bitwise.sv
// Per-bit logic slice producing both AND and XOR words.
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  output logic [WIDTH-1:0] and_word,
  output logic [WIDTH-1:0] xor_word
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign and_word[b] = opnd_x[b] & opnd_y[b];
    assign xor_word[b] = opnd_x[b] ^ opnd_y[b];
  end

endmodule

// File: rtl/alu_flags.sv
// Flag shaping: arithmetic flags pass only for arithmetic functions.
module alu_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_word,
  input  logic             is_arith,
  input  logic             arith_carry,
  input  logic             arith_ovf,
  output logic             zero_flag,
  output logic             carry_flag,
  output logic             ovf_flag
);
  always_comb begin
    zero_flag  = ~|res_word;
    carry_flag = is_arith & arith_carry;
    ovf_flag   = is_arith & arith_ovf;
  end

endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_x,
  input  logic [WIDTH-1:0] opnd_y,
  input  logic [1:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf_flag,
  output logic             zero_flag,
  output logic             carry_flag
);
  alu_fn_e          fn;
  logic [WIDTH-1:0] as_sum;
  logic             as_carry;
  logic             as_ovf;
  logic [WIDTH-1:0] and_word;
  logic [WIDTH-1:0] xor_word;
  logic             is_arith;
  logic             sub_en;

  always_comb begin
    fn       = alu_fn_e'(func_sel);
    sub_en   = (fn == FN_SUB);
    is_arith = (fn == FN_ADD) || (fn == FN_SUB);
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opnd_x    (opnd_x),
    .opnd_y    (opnd_y),
    .sub_en    (sub_en),
    .sum       (as_sum),
    .carry_out (as_carry),
    .ovf       (as_ovf)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .opnd_x   (opnd_x),
    .opnd_y   (opnd_y),
    .and_word (and_word),
    .xor_word (xor_word)
  );

  always_comb begin
    unique case (fn)
      FN_ADD,
      FN_SUB:  result = as_sum;
      FN_AND:  result = and_word;
      default: result = xor_word;
    endcase
  end

  alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_word    (result),
    .is_arith    (is_arith),
    .arith_carry (as_carry),
    .arith_ovf   (as_ovf),
    .zero_flag   (zero_flag),
    .carry_flag  (carry_flag),
    .ovf_flag    (ovf_flag)
  );

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_x,
  input logic [WIDTH-1:0] opnd_y,
  input logic [1:0]       func_sel,
  input logic [WIDTH-1:0] result,
  input logic             ovf_flag,
  input logic             zero_flag,
  input logic             carry_flag
);
  logic signed [WIDTH:0] s_add;
  logic signed [WIDTH:0] s_sub;
  logic        [WIDTH:0] u_add;

  always_comb begin
    s_add = $signed({opnd_x[WIDTH-1], opnd_x}) + $signed({opnd_y[WIDTH-1], opnd_y});
    s_sub = $signed({opnd_x[WIDTH-1], opnd_x}) - $signed({opnd_y[WIDTH-1], opnd_y});
    u_add = {1'b0, opnd_x} + {1'b0, opnd_y};

    if (func_sel == 2'd0) begin
      a_r1_add_result: assert (result == u_add[WIDTH-1:0]) else $error("R1 add result");
      a_r7_add_carry: assert (carry_flag == u_add[WIDTH]) else $error("R7 add carry");
      a_r9_add_ovf: assert (ovf_flag == (s_add[WIDTH] != s_add[WIDTH-1])) else $error("R9 add ovf");
    end
    if (func_sel == 2'd1) begin
      a_r2_sub_result: assert (result == s_sub[WIDTH-1:0]) else $error("R2 sub result");
      a_r8_sub_borrow: assert (carry_flag == (opnd_x < opnd_y)) else $error("R8 sub borrow");
      a_r9_sub_ovf: assert (ovf_flag == (s_sub[WIDTH] != s_sub[WIDTH-1])) else $error("R9 sub ovf");
    end
    if (func_sel == 2'd2) begin
      a_r3_and_result: assert ((result | opnd_x) == opnd_x && (result | opnd_y) == opnd_y &&
                               ((~result) & opnd_x & opnd_y) == '0) else $error("R3 and result");
    end
    if (func_sel == 2'd3) begin
      a_r4_xor_result: assert ((result ^ opnd_y) == opnd_x) else $error("R4 xor result");
    end
    if (func_sel[1]) begin
      a_r10_logic_flags: assert (!ovf_flag && !carry_flag) else $error("R10 logic flags");
    end
    a_r6_zero: assert (zero_flag == (result == '0)) else $error("R6 zero flag");
  end

endmodule

bind arith_logic_unit alu_checker #(.WIDTH(WIDTH)) u_alu_checker (
  .opnd_x     (opnd_x),
  .opnd_y     (opnd_y),
  .func_sel   (func_sel),
  .result     (result),
  .ovf_flag   (ovf_flag),
  .zero_flag  (zero_flag),
  .carry_flag (carry_flag)
);

// File: tb/test_arith_logic_unit.sv
module test_arith_logic_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NVEC = 14;

  // Entry layout: {func[1:0], x[31:0], y[31:0], result[31:0], {ovf,zero,carry}}
  localparam logic [100:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 3'b000},
    {2'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 3'b011},
    {2'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000, 3'b100},
    {2'd0, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 3'b111},
    {2'd1, 32'h0000_000A, 32'h0000_0003, 32'h0000_0007, 3'b000},
    {2'd1, 32'h0000_0003, 32'h0000_000A, 32'hFFFF_FFF9, 3'b001},
    {2'd1, 32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 3'b100},
    {2'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0000, 3'b101},
    {2'd1, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000, 3'b010},
    {2'd2, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'h0000_0000, 3'b010},
    {2'd2, 32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, 3'b000},
    {2'd2, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 3'b000},
    {2'd3, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h5A5A_5A5A, 3'b000},
    {2'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0000_0000, 3'b010}
  };

  logic         clk;
  logic [W-1:0] opnd_x;
  logic [W-1:0] opnd_y;
  logic [1:0]   func_sel;
  logic [W-1:0] result;
  logic         ovf_flag;
  logic         zero_flag;
  logic         carry_flag;

  int n_run;
  int n_fail;
  bit done;

  arith_logic_unit i_arith_logic_unit (
    .opnd_x     (opnd_x),
    .opnd_y     (opnd_y),
    .func_sel   (func_sel),
    .result     (result),
    .ovf_flag   (ovf_flag),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] exp_res, input logic [2:0] exp_fl);
    n_run++;
    if (result !== exp_res || {ovf_flag, zero_flag, carry_flag} !== exp_fl) begin
      n_fail++;
      $display("FAIL %s: result=%h flags(o,z,c)=%b expected result=%h flags=%b",
               tag, result, {ovf_flag, zero_flag, carry_flag}, exp_res, exp_fl);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    func_sel = f;
    opnd_x   = x;
    opnd_y   = y;
    #1;
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    done = 0;
    opnd_x = '0;
    opnd_y = '0;
    func_sel = 2'd0;
    #1;
    // Idle state: all-zero inputs under add give zero with only zero_flag set (R1 R6 R11)
    check("R6 R11 idle zero inputs", 32'h0, 3'b010);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][100:99], VEC[i][98:67], VEC[i][66:35]);
      case (VEC[i][100:99])
        2'd0: check("R1 R6 R7 R9 add vector", VEC[i][34:3], VEC[i][2:0]);
        2'd1: check("R2 R6 R8 R9 sub vector", VEC[i][34:3], VEC[i][2:0]);
        2'd2: check("R3 R6 R10 and vector", VEC[i][34:3], VEC[i][2:0]);
        default: check("R4 R6 R10 xor vector", VEC[i][34:3], VEC[i][2:0]);
      endcase
    end

    // R5: change inputs between clock edges; outputs follow with no edge
    @(posedge clk);
    #1;
    func_sel = 2'd0; opnd_x = 32'h0000_0010; opnd_y = 32'h0000_0020;
    #1;
    check("R5 combinational add", 32'h0000_0030, 3'b000);
    func_sel = 2'd1;
    #1;
    check("R5 R8 combinational sub borrow", 32'hFFFF_FFF0, 3'b001);
    func_sel = 2'd3;
    #1;
    check("R5 R10 combinational xor", 32'h0000_0030, 3'b000);

    // R10: logic functions on operands that would overflow/carry under add
    apply(2'd3, 32'h8000_0000, 32'h0000_0000);
    check("R10 xor sign operand no flags", 32'h8000_0000, 3'b000);
    apply(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R10 and all ones no flags", 32'hFFFF_FFFF, 3'b000);

    // R8 R9: sub at boundaries
    apply(2'd1, 32'h0000_0000, 32'h8000_0000);
    check("R8 R9 sub zero minus min", 32'h8000_0000, 3'b101);
    apply(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R2 R6 sub equal ones", 32'h0000_0000, 3'b010);

    // R7: carry without overflow
    apply(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R7 add carry no ovf", 32'hFFFF_FFFE, 3'b001);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule